// File: doc/BRIEF.md
# Shared Counter with Per-Core Compare Timers

This block holds one free-running 64-bit counter that all cores share. Each core also has its own 64-bit compare timer. When the counter equals a core's compare value, that core's pending flag is set. If routing is enabled for that core, the flag drives one of the core's interrupt pins, chosen by a pin number. The pending flag stays set until the core's compare value is committed again.

Cores reach the block over a single 32-bit register bus. Each access carries the index of the requesting core. Each core sees three address regions:
- a shared region, which holds the counter and its run control;
- a local window, which holds the requester's own timer registers;
- an "other" window, which reaches the timer registers of whichever core the requester last named in its selector register.

With the other window, one core can program another core's timer.

Reads are combinational and valid while `req_i` is high. Writes take effect at the rising clock edge.

Top module: `cmp_timer_top`

## Requirements
- R1: After reset the counter is 0 and stopped, and every compare value is all ones. Every pending flag is clear, every timer map register is 0, every selector is 0 and all `core_pin_o` bits are 0.
- R2: The counter low word is at address 0x00 and the high word at 0x01. Both are readable, and a write replaces that word. The run control is bit 0 at address 0x02. While that bit is 1 the counter increments by one at every clock edge; while it is 0 the counter holds.
- R3: The counter wraps from 2^64-1 to 0. A carry out of the low word increments the high word.
- R4: The compare value is written as a high word (window offset 1) and a low word (window offset 0). A high-word write is staged and has no visible effect until the next low-word write, which commits both halves together. Both halves read back as the committed value.
- R5: The pending register sits at window offset 2. Its bit 0 becomes 1 one clock after a clock in which the counter equals the compare value, and this also happens while the counter is stopped. The bit stays 1 after the counter moves on. A low-word compare write clears it, and that write wins over a match in the same cycle.
- R6: The timer map register sits at window offset 4. Bit 31 is route enable and bits [2:0] are the pin number. Output `core_pin_o[c*8+pin]` is 1 exactly when core c is pending and route enable is set. Pending bit 1 reads as pending AND route enable.
- R7: The control register sits at window offset 3. Its bit 0 reports whether the core's timer is routable, fixed by parameter. For a core that is not routable, timer map writes are ignored: the map reads 0 and the core's pins stay 0.
- R8: Addresses 0x08 + offset form the local window and address the requesting core `core_i`. Offset 5 there is the requester's selector: writes store a core index and reads return it.
- R9: Addresses 0x10 + offset form the other window. They address the core held in the requester's selector. Writes there change that target core, and the requester's own registers are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable (1 = write) |
| core_i | input | 2 | Index of the requesting core |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when idle |
| core_pin_o | output | 32 | Timer interrupt pins, 8 per core, core-major |

## Verification
The bench uses the default build: four cores with eight pins each, and core 3 made non-routable. This puts in reach routed pins, a core whose map writes are ignored, and the other window targeting a core other than the requester. Because the counter can be written, the low-word carry and the full 64-bit wrap are reached in a few cycles rather than 2^64. Stopping the counter at a chosen value also lets a compare match be made while the counter stands still.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned CNT_W = 64;

  typedef enum logic [1:0] {
    WIN_SHARED = 2'd0,
    WIN_LOCAL  = 2'd1,
    WIN_OTHER  = 2'd2,
    WIN_NONE   = 2'd3
  } win_e;

  // shared region offsets
  localparam logic [2:0] SH_CNT_LO = 3'd0;
  localparam logic [2:0] SH_CNT_HI = 3'd1;
  localparam logic [2:0] SH_RUN    = 3'd2;
  // per-core window offsets
  localparam logic [2:0] W_CMP_LO = 3'd0;
  localparam logic [2:0] W_CMP_HI = 3'd1;
  localparam logic [2:0] W_PEND   = 3'd2;
  localparam logic [2:0] W_CTL    = 3'd3;
  localparam logic [2:0] W_MAP    = 3'd4;
  localparam logic [2:0] W_SEL    = 3'd5;
endpackage

// File: rtl/shared_counter.sv
module shared_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_lo_i) cnt_q[BUS_W-1:0] <= wdata_i;
    else if (wr_hi_i) cnt_q[CNT_W-1:BUS_W] <= wdata_i;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_lo_i && !wr_hi_i && (&cnt_o)) |=> (cnt_o == '0)); // R3
endmodule

// File: rtl/cmp_core_timer.sv
module cmp_core_timer #(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned NUM_PINS = 8,
  parameter bit          ROUTABLE = 1'b1,
  localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic                wr_map_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    cmp_o,
  output logic                pend_o,
  output logic                route_en_o,
  output logic [PIN_W-1:0]    pin_sel_o,
  output logic [NUM_PINS-1:0] pins_o
);
  logic [CNT_W-1:0]       cmp_q;
  logic [CNT_W-BUS_W-1:0] hi_stage_q;
  logic                   pend_q;
  logic                   match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q      <= '1;
      hi_stage_q <= '1;
    end else begin
      if (wr_hi_i) hi_stage_q <= wdata_i[CNT_W-BUS_W-1:0];
      if (wr_lo_i) cmp_q <= {hi_stage_q, wdata_i};
    end
  end

  assign match = (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (wr_lo_i) pend_q <= 1'b0;
    else if (match) pend_q <= 1'b1;
  end

  generate
    if (ROUTABLE) begin : g_route
      logic             en_q;
      logic [PIN_W-1:0] pin_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q  <= 1'b0;
          pin_q <= '0;
        end else if (wr_map_i) begin
          en_q  <= wdata_i[BUS_W-1];
          pin_q <= wdata_i[PIN_W-1:0];
        end
      end
      assign route_en_o = en_q;
      assign pin_sel_o  = pin_q;
    end else begin : g_noroute
      logic unused_map;
      assign unused_map = wr_map_i;
      assign route_en_o = 1'b0;
      assign pin_sel_o  = '0;
    end
  endgenerate

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pins_o[p] = pend_q && route_en_o && (pin_sel_o == PIN_W'(p));
  end

  logic unused_wd;
  assign unused_wd = ^wdata_i[BUS_W-2:PIN_W];

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  AST_HI_STAGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> $stable(cmp_o)); // R4
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> !pend_o); // R5
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == cmp_o) && !wr_lo_i) |=> pend_o); // R5
  AST_PIN_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pins_o)); // R6
  AST_PIN_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_o != '0) |-> (pend_o && route_en_o)); // R6
  AST_UNROUTABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ROUTABLE |-> (pins_o == '0)); // R7
endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
  import cmpt_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PINS  = 8,
  parameter logic [NUM_CORES-1:0] ROUTABLE = 4'b0111,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [CORE_W-1:0]             core_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [BUS_W-1:0]              wdata_i,
  output logic [BUS_W-1:0]              rdata_o,
  output logic [NUM_CORES*NUM_PINS-1:0] core_pin_o
);
  win_e              win;
  logic [2:0]        off;
  logic [CORE_W-1:0] tgt;
  logic              wr;
  logic              run_q;
  logic [CNT_W-1:0]  cnt;
  logic [CORE_W-1:0] sel_q [NUM_CORES];

  logic [CNT_W-1:0] cmp    [NUM_CORES];
  logic             pend   [NUM_CORES];
  logic             ren    [NUM_CORES];
  logic [PIN_W-1:0] pin    [NUM_CORES];
  logic             wr_lo  [NUM_CORES];
  logic             wr_hi  [NUM_CORES];
  logic             wr_map [NUM_CORES];

  assign win = win_e'(addr_i[4:3]);
  assign off = addr_i[2:0];
  assign wr  = req_i && we_i;
  assign tgt = (win == WIN_OTHER) ? sel_q[core_i] : core_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else if (wr && win == WIN_SHARED && off == SH_RUN) run_q <= wdata_i[0];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q[c] <= '0;
      else if (wr && win == WIN_LOCAL && off == W_SEL && core_i == CORE_W'(c))
        sel_q[c] <= wdata_i[CORE_W-1:0];
    end
  end

  shared_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .wr_lo_i (wr && win == WIN_SHARED && off == SH_CNT_LO),
    .wr_hi_i (wr && win == WIN_SHARED && off == SH_CNT_HI),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    assign hit       = wr && (win == WIN_LOCAL || win == WIN_OTHER) && tgt == CORE_W'(c);
    assign wr_lo[c]  = hit && off == W_CMP_LO;
    assign wr_hi[c]  = hit && off == W_CMP_HI;
    assign wr_map[c] = hit && off == W_MAP;

    cmp_core_timer #(
      .CNT_W(CNT_W), .BUS_W(BUS_W), .NUM_PINS(NUM_PINS), .ROUTABLE(ROUTABLE[c])
    ) i_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .wr_lo_i    (wr_lo[c]),
      .wr_hi_i    (wr_hi[c]),
      .wr_map_i   (wr_map[c]),
      .wdata_i    (wdata_i),
      .cmp_o      (cmp[c]),
      .pend_o     (pend[c]),
      .route_en_o (ren[c]),
      .pin_sel_o  (pin[c]),
      .pins_o     (core_pin_o[c*NUM_PINS +: NUM_PINS])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (req_i) begin
      if (win == WIN_SHARED) begin
        case (off)
          SH_CNT_LO: rdata_o = cnt[BUS_W-1:0];
          SH_CNT_HI: rdata_o = cnt[CNT_W-1:BUS_W];
          SH_RUN:    rdata_o = {{(BUS_W-1){1'b0}}, run_q};
          default:   rdata_o = '0;
        endcase
      end else if ((win == WIN_LOCAL || win == WIN_OTHER) && int'(tgt) < NUM_CORES) begin
        case (off)
          W_CMP_LO: rdata_o = cmp[tgt][BUS_W-1:0];
          W_CMP_HI: rdata_o = cmp[tgt][CNT_W-1:BUS_W];
          W_PEND:   rdata_o = {{(BUS_W-2){1'b0}}, pend[tgt] && ren[tgt], pend[tgt]};
          W_CTL:    rdata_o = {{(BUS_W-1){1'b0}}, ROUTABLE[tgt]};
          W_MAP:    rdata_o = {ren[tgt], {(BUS_W-1-PIN_W){1'b0}}, pin[tgt]};
          W_SEL:    rdata_o = (win == WIN_LOCAL) ?
                              {{(BUS_W-CORE_W){1'b0}}, sel_q[core_i]} : '0;
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  logic unused_top;
  assign unused_top = ^wdata_i[BUS_W-1:CORE_W];

  AST_RESET_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (core_pin_o == '0)); // R1
  AST_OTHER_NOT_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && win == WIN_OTHER && off == W_CMP_LO && sel_q[core_i] != core_i)
      |=> $stable(cmp[core_i])); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0)); // R8
endmodule

// File: tb/test_cmp_timer_top.sv
module test_cmp_timer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  core = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_timer_top i_cmp_timer_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .core_i(core),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .core_pin_o(pins)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] c, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; core = c; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] c, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; core = c; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pins", pins, 32'h0);
    rd(0, 5'h00, d); chk("R1 cnt lo", d, 32'h0);
    rd(0, 5'h02, d); chk("R1 run", d, 32'h0);
    rd(1, 5'h08, d); chk("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(2, 5'h09, d); chk("R1 cmp hi", d, 32'hFFFF_FFFF);
    rd(0, 5'h0A, d); chk("R1 pend", d, 32'h0);
    rd(0, 5'h0C, d); chk("R1 map", d, 32'h0);
    rd(3, 5'h0D, d); chk("R1 sel", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(0, 5'h00, 32'd100);
    wr(0, 5'h01, 32'd0);
    wr(0, 5'h02, 32'd1);
    repeat (8) @(negedge clk);
    wr(0, 5'h02, 32'd0);  // 10 increments
    rd(0, 5'h00, d); chk("R2 count lo", d, 32'd110);
    rd(0, 5'h01, d); chk("R2 count hi", d, 32'd0);
    repeat (5) @(negedge clk);
    rd(0, 5'h00, d); chk("R2 hold", d, 32'd110);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(0, 5'h00, 32'hFFFF_FFFF);
    wr(0, 5'h01, 32'h0);
    wr(0, 5'h02, 32'd1);
    wr(0, 5'h02, 32'd0);  // 2 increments
    rd(0, 5'h00, d); chk("R3 carry lo", d, 32'h1);
    rd(0, 5'h01, d); chk("R3 carry hi", d, 32'h1);
    wr(0, 5'h00, 32'hFFFF_FFFE);
    wr(0, 5'h01, 32'hFFFF_FFFF);
    wr(0, 5'h02, 32'd1);
    repeat (1) @(negedge clk);
    wr(0, 5'h02, 32'd0);  // 3 increments
    rd(0, 5'h00, d); chk("R3 wrap lo", d, 32'h1);
    rd(0, 5'h01, d); chk("R3 wrap hi", d, 32'h0);
  endtask

  task automatic t_stage();
    logic [31:0] d;
    wr(1, 5'h09, 32'h0000_ABCD);
    rd(1, 5'h09, d); chk("R4 hi staged", d, 32'hFFFF_FFFF);
    wr(1, 5'h08, 32'h0000_0010);
    rd(1, 5'h09, d); chk("R4 hi commit", d, 32'h0000_ABCD);
    rd(1, 5'h08, d); chk("R4 lo commit", d, 32'h0000_0010);
  endtask

  task automatic t_match_route();
    logic [31:0] d;
    wr(0, 5'h00, 32'd0);
    wr(0, 5'h01, 32'd0);
    wr(0, 5'h09, 32'd0);
    wr(0, 5'h08, 32'd5);
    rd(0, 5'h0A, d); chk("R5 not yet", d, 32'h0);
    wr(0, 5'h02, 32'd1);
    repeat (8) @(negedge clk);
    wr(0, 5'h02, 32'd0);  // counter 10, passed 5
    rd(0, 5'h0A, d); chk("R5 sticky", d, 32'h1);
    chk("R6 unrouted pins", pins, 32'h0);
    wr(0, 5'h0C, 32'h8000_0003);
    @(negedge clk);
    chk("R6 pin3", pins, 32'h0000_0008);
    rd(0, 5'h0A, d); chk("R6 pend timer bit", d, 32'h3);
    rd(0, 5'h0C, d); chk("R6 map read", d, 32'h8000_0003);
    wr(0, 5'h08, 32'h100);
    rd(0, 5'h0A, d); chk("R5 cleared", d, 32'h0);
    chk("R6 pin drop", pins, 32'h0);
  endtask

  task automatic t_unroutable();
    logic [31:0] d;
    rd(3, 5'h0B, d); chk("R7 ctl core3", d, 32'h0);
    rd(0, 5'h0B, d); chk("R7 ctl core0", d, 32'h1);
    wr(3, 5'h0C, 32'h8000_0001);
    rd(3, 5'h0C, d); chk("R7 map ignored", d, 32'h0);
    wr(3, 5'h09, 32'd0);
    wr(3, 5'h08, 32'd10);  // counter stopped at 10
    @(negedge clk);
    rd(3, 5'h0A, d); chk("R5 match while stopped", d, 32'h1);
    chk("R7 core3 pins", pins, 32'h0);
  endtask

  task automatic t_other();
    logic [31:0] d;
    wr(0, 5'h0D, 32'd2);
    rd(0, 5'h0D, d); chk("R8 sel read", d, 32'd2);
    wr(0, 5'h11, 32'h0000_1234);
    wr(0, 5'h10, 32'h0000_5678);
    rd(2, 5'h08, d); chk("R9 target lo", d, 32'h0000_5678);
    rd(2, 5'h09, d); chk("R9 target hi", d, 32'h0000_1234);
    rd(0, 5'h08, d); chk("R9 self untouched", d, 32'h100);
    rd(0, 5'h10, d); chk("R9 other read", d, 32'h0000_5678);
    wr(0, 5'h14, 32'h8000_0005);
    rd(2, 5'h0C, d); chk("R9 other map", d, 32'h8000_0005);
    rd(0, 5'h0C, d); chk("R8 own map", d, 32'h8000_0003);
    rd(1, 5'h08, d); chk("R8 local core1", d, 32'h0000_0010);
  endtask

  initial begin
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_stage();
    t_match_route();
    t_unroutable();
    t_other();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule